// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns five external interrupt pins into prioritised interrupt requests for a CPU. The lines are numbered 0, 1, 2, 3 and 6. Each line has a mask bit, a two-bit sense field and a sticky flag. The sense field picks one of four conditions: low level, either edge, falling edge or rising edge. Software configures the block through a small register port made of an address, write data, a write strobe and combinational read data. The CPU clears flags either by writing ones to them or by acknowledging the vector that is currently presented.

Every pin first passes through a two-flop synchronizer. Each line then compares its synchronized value at successive clock ticks. A pin change is seen whatever drives the pin, so software can raise an interrupt by driving the pin itself. Changing a sense field can produce a false trigger, so software should mask the line and clear its flag before unmasking it again. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `eisc_ctrl`

## Requirements
- R1: After reset, the mask, control A, control B and flag registers all read 0 (every line in low-level sense mode), `irq_o` is 0 and `vec_o` is 0.
- R2: Register addresses are 0 for mask, 1 for control A, 2 for control B and 3 for flags. Mask and flag bit n belongs to line n, and bits 4 and 5 always read 0. Control A holds line k's sense field at bits [2k+1:2k] for k = 0 to 3. Control B holds line 6's field at bits [1:0], and its other bits read 0. A write takes effect at the next clock edge.
- R3: Sense codes are 01 for either edge, 10 for falling edge and 11 for rising edge. A matching pin transition sets the line's flag at the third rising clock edge after the pin changes. A transition that does not match leaves the flag clear.
- R4: In sense code 00 (low level), no flag is set. A masked-in line requests for as long as its pin is low, starting from the second clock edge after the pin falls and ending at the second clock edge after it rises.
- R5: A flag is set whether or not the line is masked. The mask bit only gates the line's request.
- R6: Writing address 3 clears each flag whose write-data bit is 1 and leaves the other flags alone. When a clear and a new trigger for the same line meet at one edge, the flag stays set.
- R7: A pulse on `ack_i` clears the flag of the line whose vector is on `vec_o` at that edge.
- R8: `vec_o` is 1 + the number of the lowest-numbered line that is requesting, or 0 when no line requests. `irq_o` is 1 exactly when `gie_i` is 1 and `vec_o` is non-zero.
- R9: Line 6 uses input slot `pin_i[4]`, mask and flag bit 6, control B bits [1:0] and vector 7. It has the lowest priority of the five lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie_i | input | 1 | Global interrupt enable |
| pin_i | input | 5 | External pins for lines 0, 1, 2, 3, 6 (slots 0..4) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| ack_i | input | 1 | Acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 3 | Vector index of the winning line, 0 when none |

## Verification
Stimulus is applied 2 ns after a rising edge, and results are sampled at the falling edge or shortly after the drive. Each check therefore names the exact edge at which a result is due. An edge-mode flag is due at the third edge after the pin moves: the bench reads the flag register after two edges and expects it clear, then after the third edge and expects it set. A low-level request is due at the second edge. Register writes, write-one-to-clear and acknowledge take effect at the single edge that commits them. The behavioural reference model advances at every edge using a history of pin samples and is compared on every falling edge, so no latency can drift without a miscompare.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int NLINES = 5;
  localparam int VEC_W  = 3;

  localparam logic [1:0] ADR_MASK = 2'd0;
  localparam logic [1:0] ADR_CTLA = 2'd1;
  localparam logic [1:0] ADR_CTLB = 2'd2;
  localparam logic [1:0] ADR_FLAG = 2'd3;

  // Slot to line number: slots 0..3 are lines 0..3, slot 4 is line 6.
  function automatic logic [2:0] line_id(input int slot);
    return (slot < 4) ? slot[2:0] : 3'd6;
  endfunction
endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/eisc_sense.sv
module eisc_sense
  import eisc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       trig_o,
  output logic       low_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_i;
  end

  always_comb begin
    unique case (sense_e'(mode_i))
      SENSE_ANY:  trig_o = lvl_i ^ prev_q;
      SENSE_FALL: trig_o = prev_q & ~lvl_i;
      SENSE_RISE: trig_o = ~prev_q & lvl_i;
      default:    trig_o = 1'b0;
    endcase
  end

  assign low_o = (sense_e'(mode_i) == SENSE_LOW) & ~lvl_i;
endmodule

// File: rtl/eisc_prio.sv
module eisc_prio
  import eisc_pkg::*;
(
  input  logic [NLINES-1:0] req_i,
  output logic [VEC_W-1:0]  vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = line_id(i) + 3'd1;
    end
  end
endmodule

// File: rtl/eisc_ctrl.sv
module eisc_ctrl
  import eisc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie_i,
  input  logic [NLINES-1:0] pin_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NLINES-1:0]      mask_q, flag_q, lvl, trig, low, req, clr;
  logic [NLINES-1:0][1:0] mode_q;
  logic [DATA_W-1:0]      mask_rd, flag_rd, ctla_rd, ctlb_rd;

  wire wr_mask = reg_we_i && (reg_addr_i == ADR_MASK);
  wire wr_ctla = reg_we_i && (reg_addr_i == ADR_CTLA);
  wire wr_ctlb = reg_we_i && (reg_addr_i == ADR_CTLB);
  wire wr_flag = reg_we_i && (reg_addr_i == ADR_FLAG);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam logic [2:0] LID = line_id(i);

    eisc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i[i]), .q(lvl[i])
    );

    eisc_sense u_sense (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[i]), .mode_i(mode_q[i]),
      .trig_o(trig[i]), .low_o(low[i])
    );

    logic mode_wr;
    logic [1:0] mode_d;
    if (i < 4) begin : g_ctla
      assign mode_wr = wr_ctla;
      assign mode_d  = reg_wdata_i[2*i +: 2];
    end else begin : g_ctlb
      assign mode_wr = wr_ctlb;
      assign mode_d  = reg_wdata_i[1:0];
    end

    assign clr[i] = (wr_flag && reg_wdata_i[LID]) ||
                    (ack_i && (vec_o == LID + 3'd1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[i] <= 1'b0;
        mode_q[i] <= SENSE_LOW;
        flag_q[i] <= 1'b0;
      end else begin
        if (wr_mask) mask_q[i] <= reg_wdata_i[LID];
        if (mode_wr) mode_q[i] <= mode_d;
        flag_q[i] <= (flag_q[i] & ~clr[i]) | trig[i];
      end
    end

    assign req[i] = mask_q[i] &
                    ((mode_q[i] == SENSE_LOW) ? low[i] : flag_q[i]);
  end

  eisc_prio u_prio (.req_i(req), .vec_o(vec_o));

  assign irq_o = gie_i && (vec_o != '0);

  always_comb begin
    mask_rd = '0;
    flag_rd = '0;
    ctla_rd = '0;
    ctlb_rd = '0;
    for (int i = 0; i < NLINES; i++) begin
      mask_rd[line_id(i)] = mask_q[i];
      flag_rd[line_id(i)] = flag_q[i];
      if (i < 4) ctla_rd[2*i +: 2] = mode_q[i];
      else       ctlb_rd[1:0]      = mode_q[i];
    end
    unique case (reg_addr_i)
      ADR_MASK: reg_rdata_o = mask_rd;
      ADR_CTLA: reg_rdata_o = ctla_rd;
      ADR_CTLB: reg_rdata_o = ctlb_rd;
      default:  reg_rdata_o = flag_rd;
    endcase
  end
endmodule

// File: rtl/eisc_chk.sv
module eisc_chk
  import eisc_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   gie_i,
  input logic                   reg_we_i,
  input logic [1:0]             reg_addr_i,
  input logic [7:0]             reg_wdata_i,
  input logic                   ack_i,
  input logic                   irq_o,
  input logic [VEC_W-1:0]       vec_o,
  input logic [NLINES-1:0]      mask_q,
  input logic [NLINES-1:0]      flag_q,
  input logic [NLINES-1:0][1:0] mode_q
);
  // R8
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !irq_o);

  // R8
  irq_has_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o != '0));

  // R5
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0));

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    localparam logic [2:0] LID = line_id(i);

    // R3
    flag_set_by_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> ($past(mode_q[i]) != 2'b00));

    // R6
    flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |->
        ($past(reg_we_i && (reg_addr_i == ADR_FLAG) && reg_wdata_i[LID]) || $past(ack_i)));
  end
endmodule

bind eisc_ctrl eisc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .ack_i(ack_i),
  .irq_o(irq_o), .vec_o(vec_o), .mask_q(mask_q), .flag_q(flag_q),
  .mode_q(mode_q)
);

// File: tb/eisc_ctrl_test.sv
`timescale 1ns/1ps
module eisc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gie_i = 1'b0;
  logic [4:0] pin_i = 5'h1f;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_rdata_o;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  eisc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .pin_i(pin_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_we_i(reg_we_i),
    .reg_rdata_o(reg_rdata_o), .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  // Behavioural reference model
  bit [7:0] m_mask, m_cta, m_ctb, m_flag;
  bit [4:0] hist[$];

  function automatic int lid(int s);
    return (s < 4) ? s : 6;
  endfunction

  function automatic int mode_of(int s);
    return (s < 4) ? int'(m_cta[2*s +: 2]) : int'(m_ctb[1:0]);
  endfunction

  function automatic int m_vec();
    for (int s = 0; s < 5; s++) begin
      bit r;
      r = (mode_of(s) == 0) ? (hist[1][s] == 1'b0) : m_flag[lid(s)];
      if (m_mask[lid(s)] && r) return lid(s) + 1;
    end
    return 0;
  endfunction

  function automatic bit [7:0] m_rd(bit [1:0] a);
    case (a)
      2'd0: return m_mask;
      2'd1: return m_cta;
      2'd2: return m_ctb;
      default: return m_flag;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_cta = 0; m_ctb = 0; m_flag = 0;
      hist = '{5'h1f, 5'h1f, 5'h1f};
    end else begin
      bit [7:0] nf;
      int v;
      v  = m_vec();
      nf = m_flag;
      if (ack_i && v != 0) nf[v-1] = 1'b0;
      if (reg_we_i && reg_addr_i == 2'd3) nf = nf & ~reg_wdata_i;
      for (int s = 0; s < 5; s++) begin
        bit a, b, t;
        a = hist[1][s];
        b = hist[2][s];
        case (mode_of(s))
          1: t = a != b;
          2: t = b && !a;
          3: t = !b && a;
          default: t = 1'b0;
        endcase
        if (t) nf[lid(s)] = 1'b1;
      end
      m_flag = nf;
      if (reg_we_i && reg_addr_i == 2'd0) m_mask = reg_wdata_i & 8'h4f;
      if (reg_we_i && reg_addr_i == 2'd1) m_cta = reg_wdata_i;
      if (reg_we_i && reg_addr_i == 2'd2) m_ctb = reg_wdata_i & 8'h03;
      hist.push_front(pin_i);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ev;
      ev = m_vec();
      n_vec++;
      if (vec_o !== 3'(ev) || irq_o !== (gie_i && ev != 0) ||
          reg_rdata_o !== m_rd(reg_addr_i)) begin
        n_bad++;
        $display("FAIL %s model: vec=%0d irq=%0b rd=%h exp vec=%0d irq=%0b rd=%h",
                 phase, vec_o, irq_o, reg_rdata_o, ev, gie_i && ev != 0,
                 m_rd(reg_addr_i));
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(bit [1:0] a, output int v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
  endtask

  initial begin
    int v;
    step(3);
    rst_n = 1'b1;
    step();
    // R1: reset state
    phase = "R1";
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irq", irq_o, 0);
    chk("R1 vec", vec_o, 0);

    // R2: register map
    phase = "R2";
    wr(2'd0, 8'hff); rd(2'd0, v); chk("R2 mask", v, 8'h4f);
    wr(2'd1, 8'he4); rd(2'd1, v); chk("R2 ctla", v, 8'he4);
    wr(2'd2, 8'hff); rd(2'd2, v); chk("R2 ctlb", v, 8'h03);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);

    // R3 and R5: line0 rising, line1 falling, line2 either; all masked out
    phase = "R3";
    wr(2'd1, 8'h1b);
    step(3);
    pin_i[1] = 1'b0;
    step(2); rd(2'd3, v); chk("R3 fall not yet", v, 0);
    step();  rd(2'd3, v); chk("R3 fall at edge 3", v, 8'h02);
    chk("R5 masked no irq", irq_o, 0);
    pin_i[0] = 1'b0;
    step(4); rd(2'd3, v); chk("R3 rising ignores fall", v, 8'h02);
    pin_i[0] = 1'b1;
    step(3); rd(2'd3, v); chk("R3 rising sets", v, 8'h03);
    pin_i[2] = 1'b0;
    step(3); rd(2'd3, v); chk("R3 either edge", v, 8'h07);

    // R6: write-one-to-clear, then collision with trigger
    phase = "R6";
    wr(2'd3, 8'h01); rd(2'd3, v); chk("R6 w1c bit0", v, 8'h06);
    pin_i[2] = 1'b1;
    step(2);
    wr(2'd3, 8'h04); rd(2'd3, v); chk("R6 trigger wins", v, 8'h06);

    // R7 and R8: priority, ack and global enable
    phase = "R7";
    wr(2'd0, 8'h06);
    #1; chk("R8 no gie", irq_o, 0);
    gie_i = 1'b1;
    #1; chk("R8 irq", irq_o, 1);
    chk("R8 vec lowest", vec_o, 2);
    ack(); #1; chk("R7 ack clears line1", vec_o, 3);
    ack(); #1; chk("R7 ack clears line2", vec_o, 0);
    chk("R8 idle irq", irq_o, 0);

    // R4: line3 low level
    phase = "R4";
    wr(2'd0, 8'h08);
    pin_i[3] = 1'b0;
    step(); #1; chk("R4 not yet", irq_o, 0);
    step(); #1; chk("R4 level req", vec_o, 4);
    rd(2'd3, v); chk("R4 no flag", v, 0);

    // R9: line6 rising, behind line3
    phase = "R9";
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h48);
    pin_i[4] = 1'b0; step(3);
    pin_i[4] = 1'b1; step(3);
    rd(2'd3, v); chk("R9 flag bit6", v, 8'h40);
    chk("R9 line3 first", vec_o, 4);
    pin_i[3] = 1'b1;
    step(2); #1; chk("R4 release", vec_o, 7);
    ack(); #1; chk("R9 ack line6", vec_o, 0);
    step(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule